// File: doc/BRIEF.md
# Wide-Word CRC-32 Remainder Engine

This block computes the CRC-32 remainder of a message that arrives as one 64-bit word per clock. It treats the 32-bit state as a linear system: advancing a shift-register CRC by 32 serial steps is one fixed 32x32 binary matrix. The block applies that matrix twice per word and folds one 32-bit half of the word in after each application. One cycle therefore does the work of 64 serial shift steps.

The state starts at zero after reset or after a clear. Each word with the valid strobe high advances the state. Within a word, bit 63 is the first bit of the message stream and bit 0 is the last. The caller appends 32 zero bits to the message so that the message and the padding together fill whole words. When the last word has been absorbed, the state holds the remainder of the message polynomial times x^32, divided by the generator polynomial. A message of k bits needs (k+32)/64 cycles. A 32-bit-wide datapath would need twice as many.

Top module: `crc_wide_fold`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes zero at that edge.
- R2: When `clr` is high at a rising edge, the state becomes zero at that edge. This holds even when `data_vld` is high in the same cycle.
- R3: When `clr` and `data_vld` are both low at a rising edge, the state keeps its value, whatever is on `data_in`.
- R4: A word taken with `data_vld` high moves the state to the value that 64 serial steps of the augmented shift register produce. Each step is new = {old[30:0], bit} XOR (old[31] ? 32'h04C11DB7 : 0). The bits are fed from `data_in[63]` down to `data_in[0]`.
- R5: Feed a message of 64n-32 bits, followed by 32 zero bits, as n words with the first message bit in bit 63 of the first word. The state then equals the message polynomial times x^32, reduced modulo x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1.
- R6: From a zero state, a word whose upper 32 bits are zero leaves its lower 32 bits as the new state.
- R7: The state changes only at the rising edge where `data_vld` is sampled high. Between edges it is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the state; wins over `data_vld` |
| data_vld | input | 1 | Absorb `data_in` at this edge |
| data_in | input | 64 | Message word; bit 63 is the first bit in stream order |
| crc_out | output | 32 | Current CRC state (the remainder once padding is absorbed) |

## Verification
The embedded assertions check, on every cycle, that reset and clear give zero, that idle cycles hold the state, and that a short word on a zero state gives its own lower half. The arithmetic is shown only by the bench's scenarios. These are the correctness of the matrix contents, the serial equivalence for every single-bit word and for long random word chains, and whole padded messages checked against a polynomial division done a different way.

// File: rtl/crc_pkg.sv
// Package: shared defaults for the wide CRC engine.
// Assumes the generator is given without its implicit top (x^W) term.
package crc_pkg;
    localparam int unsigned    CRC_W_DEF  = 32;
    localparam int unsigned    DATA_W_DEF = 64;
    localparam logic [31:0]    CRC32_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/crc_fmat_mul.sv
// Module: crc_fmat_mul
// Multiplies a W-bit state by the matrix that advances the augmented CRC
// shift register STEPS serial steps with zero input. The matrix rows are
// built at elaboration by constant functions from POLY. Each output bit is
// the XOR reduction of the masked input.
// Assumes POLY excludes the x^W coefficient.
module crc_fmat_mul #(
    parameter int unsigned    W     = 32,
    parameter logic [W-1:0]   POLY  = 32'h04C1_1DB7,
    parameter int unsigned    STEPS = W
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);
    // Serial advance of a state by STEPS zero-input shifts.
    function automatic logic [W-1:0] lfsr_adv(input logic [W-1:0] s);
        logic [W-1:0] r;
        r = s;
        for (int k = 0; k < int'(STEPS); k++) begin
            r = {r[W-2:0], 1'b0} ^ (r[W-1] ? POLY : '0);
        end
        return r;
    endfunction

    // Row i of the matrix: bit j is element (i, j).
    function automatic logic [W-1:0] row_mask(input int i);
        logic [W-1:0] m;
        logic [W-1:0] col;
        m = '0;
        for (int j = 0; j < int'(W); j++) begin
            col  = lfsr_adv(W'(1) << j);
            m[j] = col[i];
        end
        return m;
    endfunction

    // One AND-XOR tree per output bit.
    for (genvar gi = 0; gi < int'(W); gi++) begin : g_row
        localparam logic [W-1:0] MASK = row_mask(gi);
        assign vec_o[gi] = ^(vec_i & MASK);
    end
endmodule

// File: rtl/crc_fold_stage.sv
// Module: crc_fold_stage
// Advances the state W serial steps and absorbs one W-bit slice of data.
// From a zero state, W shifted-in bits land unchanged in the register. So
// absorbing the slice is a plain XOR after the matrix product.
// Assumes the slice MSB is the earliest bit in stream order.
module crc_fold_stage #(
    parameter int unsigned  W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] half_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] adv;

    crc_fmat_mul #(.W(W), .POLY(POLY), .STEPS(W)) u_fmat (
        .vec_i (state_i),
        .vec_o (adv)
    );

    // Fold the data slice into the advanced state.
    assign state_o = adv ^ half_i;
endmodule

// File: rtl/crc_wide_fold.sv
// Module: crc_wide_fold
// CRC remainder engine that takes DATA_W bits per clock. The word is split
// into DATA_W/CRC_W slices, and the slices are folded in from the top one
// down, each after a CRC_W-step matrix advance. The state register is
// cleared by reset or clr, advanced on data_vld and held otherwise.
// Assumes DATA_W is a whole multiple of CRC_W.
module crc_wide_fold
    import crc_pkg::*;
#(
    parameter int unsigned        CRC_W  = CRC_W_DEF,
    parameter int unsigned        DATA_W = DATA_W_DEF,
    parameter logic [CRC_W-1:0]   POLY   = CRC32_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              data_vld,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int unsigned NFOLD = DATA_W / CRC_W;

    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] chain [NFOLD+1];

    assign chain[0] = state_q;

    // Chain of fold stages, one per data slice, earliest slice first.
    for (genvar gk = 0; gk < int'(NFOLD); gk++) begin : g_fold
        crc_fold_stage #(.W(CRC_W), .POLY(POLY)) u_stage (
            .state_i (chain[gk]),
            .half_i  (data_in[DATA_W-1-gk*CRC_W -: CRC_W]),
            .state_o (chain[gk+1])
        );
    end

    // State register: reset/clear to zero, absorb on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= '0;
        else if (clr)      state_q <= '0;
        else if (data_vld) state_q <= chain[NFOLD];
    end

    assign crc_out = state_q;

    // R1
    rst_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (crc_out == '0));

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !data_vld) |=> $stable(crc_out));

    // R6
    short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && data_vld && crc_out == '0 && data_in[DATA_W-1:CRC_W] == '0)
        |=> (crc_out == $past(data_in[CRC_W-1:0])));
endmodule

// File: tb/crc_wide_fold_tb.sv
// Bench for crc_wide_fold. Its models are a bit-serial augmented register
// and a direct polynomial division, both written from the requirements.
module crc_wide_fold_tb;
    localparam logic [31:0] P = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst_n, clr, data_vld;
    logic [63:0] data_in;
    logic [31:0] crc_out;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    crc_wide_fold u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .data_vld(data_vld),
        .data_in(data_in), .crc_out(crc_out)
    );

    // Serial augmented register over one word, bit 63 first.
    function automatic logic [31:0] ser_word(input logic [31:0] s, input logic [63:0] w);
        logic [31:0] r;
        r = s;
        for (int b = 63; b >= 0; b--) r = {r[30:0], w[b]} ^ (r[31] ? P : 32'h0);
        return r;
    endfunction

    // Direct division step: remainder of M*x^32 mod G, one message bit.
    function automatic logic [31:0] div_bit(input logic [31:0] r, input logic b);
        return {r[30:0], 1'b0} ^ ((r[31] ^ b) ? P : 32'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge and return at the next falling edge.
    task automatic step(input logic c, input logic v, input logic [63:0] w);
        clr = c; data_vld = v; data_in = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        logic [63:0] w;
        rst_n = 1'b0; clr = 1'b0; data_vld = 1'b0; data_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", crc_out, 32'h0);
        rst_n = 1'b1;

        // R6: walking ones and patterns in the lower half from a zero state.
        for (int i = 0; i < 36; i++) begin
            logic [31:0] v;
            v = (i < 32) ? (32'h1 << i) : $urandom;
            step(1'b1, 1'b0, '0);
            step(1'b0, 1'b1, {32'h0, v});
            chk("R6 short word", crc_out, v);
        end

        // R4: every single-bit word from a zero state.
        for (int b = 0; b < 64; b++) begin
            step(1'b1, 1'b0, '0);
            step(1'b0, 1'b1, 64'h1 << b);
            chk("R4 unit word", crc_out, ser_word(32'h0, 64'h1 << b));
        end

        // R4: long random chain.
        step(1'b1, 1'b0, '0);
        exp = '0;
        for (int i = 0; i < 200; i++) begin
            w = {$urandom, $urandom};
            if (i % 7 == 0) w = ~64'h0;
            step(1'b0, 1'b1, w);
            exp = ser_word(exp, w);
            chk("R4 chain", crc_out, exp);
        end

        // R3: idle cycles with changing data.
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, {$urandom, $urandom});
            chk("R3 hold", crc_out, exp);
        end

        // R7: no change before the edge, update after it.
        w = {$urandom, $urandom};
        clr = 1'b0; data_vld = 1'b1; data_in = w;
        #1;
        chk("R7 before edge", crc_out, exp);
        @(negedge clk);
        exp = ser_word(exp, w);
        chk("R7 after edge", crc_out, exp);

        // R2: clear beats valid.
        step(1'b1, 1'b1, {$urandom, $urandom});
        chk("R2 clear priority", crc_out, 32'h0);

        // R1: reset from a nonzero state.
        step(1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 64'h1);
        chk("R1 reset midstream", crc_out, 32'h0);
        rst_n = 1'b1;

        // R5: padded messages against direct division.
        for (int n = 1; n <= 6; n++) begin
            for (int m = 0; m < 5; m++) begin
                logic [31:0] rem;
                rem = '0;
                step(1'b1, 1'b0, '0);
                for (int k = 0; k < n; k++) begin
                    w = {$urandom, $urandom};
                    if (m == 0) w = ~64'h0;
                    if (k == n - 1) w[31:0] = 32'h0;
                    for (int b = 63; b >= 0; b--)
                        if (k < n - 1 || b >= 32) rem = div_bit(rem, w[b]);
                    step(1'b0, 1'b1, w);
                end
                chk("R5 message remainder", crc_out, rem);
            end
        end

        step(1'b0, 1'b0, '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule